// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the hardware steps that start an exception or interrupt in a small 32-bit processor core. Four request lines can raise an entry: a non-maskable interrupt, a bus fault, a software break and an external interrupt whose vector comes from an interrupt controller. When the sequencer is idle and a request is present, it picks one request by fixed priority and captures the core context it needs. That context is the current PC, the pending delay-slot count, the flags word, the vector-table base, the live stack pointer and the stored kernel stack pointer.

From that snapshot it works out the vector number, the return address and which return register receives it, the cause word, the shifted flags word and the stack swap. It then reads the handler address from the vector table at base plus four times the vector. The request channel of that read is valid/ready: `rd_req_valid` stays high with `rd_addr` unchanged until `rd_req_ready` is seen high at a clock edge. The response channel is valid/ready as well: `rd_rsp_ready` is high only while a response is awaited, and a beat is taken in a cycle where both are high. Nothing is committed to the core before that response arrives. One cycle after the response beat, `done` pulses together with the write strobes, and all result outputs are valid in that cycle. The result values then hold until the next entry is accepted.

The core applies the writes on `done`. A bus fault raised while a bus-fault entry is in flight is fatal: the sequencer flags an error and accepts no further entry until reset.

Top module: `exc_entry_seq`

## Requirements
- R1: When several requests are high in an idle cycle, exactly one is taken, by priority: NMI first, then bus fault, then break, then external interrupt.
- R2: A break entry uses `trap_vec` as its vector and returns to the exception return register (`ret_to_exc` pulses with `done`, `ret_to_nmi` stays low).
- R3: An NMI entry uses vector 0 and returns to the NMI return register (`ret_to_nmi` pulses). The mask flag (flags bit 9) is cleared before the flags shift, so flags_out bit 19 is 0.
- R4: A bus-fault entry uses `fault_vec` as its vector and returns to the exception return register.
- R5: An external-interrupt entry uses `irq_vec` as its vector and returns to the exception return register.
- R6: `status_out` holds the low 8 bits of the vector in bits 15:8, and all its other bits are zero.
- R7: `ret_addr` equals the captured PC minus `dslot_cnt` (zero-extended, modulo 2^32). `dslot_clr` pulses with `done` exactly when that count was nonzero.
- R8: The vector read is issued at `vbase + 4*vector` (modulo 2^32), and the address stays stable while the request is stalled.
- R9: When flags bit 8 (user mode) is set on entry, `user_sp_out` equals `sp_in`, `sp_out` equals `kern_sp_in` and `user_sp_we` pulses with `done`. Otherwise `sp_out` equals `sp_in` and `user_sp_we` stays low.
- R10: `flags_out` equals {f[31:30], f[19:0], 10'b0}, where f is the entry flags word (after the R3 mask clear). Bit 8 (user mode) therefore always ends at 0.
- R11: `done` pulses for one cycle, one cycle after the response beat, and `new_pc` then equals the response data. No write strobe is high outside `done`.
- R12: Requests that arrive while `busy` is high are ignored. They neither change the running entry nor start a later one once they are gone.
- R13: A bus-fault request while a bus-fault entry is busy sets `fatal_err`, which stays set until reset. While it is set no request is accepted.
- R14: After reset, `busy`, `done`, `rd_req_valid`, all write strobes and `fatal_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_nmi | input | 1 | Non-maskable interrupt request |
| req_bflt | input | 1 | Bus-fault request |
| req_brk | input | 1 | Software break request |
| req_irq | input | 1 | External interrupt request |
| trap_vec | input | VEC_W | Vector for breaks |
| fault_vec | input | VEC_W | Latched bus-fault vector |
| irq_vec | input | VEC_W | Vector from the interrupt controller |
| cur_pc | input | 32 | Current PC |
| dslot_cnt | input | DS_W | Pending delay-slot count, 0 when none |
| flags_in | input | 32 | Flags word |
| vbase | input | 32 | Vector table base |
| sp_in | input | 32 | Live stack pointer |
| kern_sp_in | input | 32 | Stored kernel stack pointer |
| rd_req_valid | output | 1 | Vector read request valid |
| rd_req_ready | input | 1 | Vector read request accepted |
| rd_addr | output | 32 | Vector read address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Sequencer awaiting response |
| rd_rsp_data | input | 32 | Read response data (handler PC) |
| busy | output | 1 | Entry in progress |
| done | output | 1 | One-cycle commit pulse |
| new_pc | output | 32 | Handler PC |
| ret_addr | output | 32 | Return address to save |
| ret_to_exc | output | 1 | Write strobe, exception return register |
| ret_to_nmi | output | 1 | Write strobe, NMI return register |
| status_out | output | 32 | Cause word |
| flags_out | output | 32 | Shifted flags word |
| sp_out | output | 32 | New stack pointer |
| user_sp_out | output | 32 | Value for user stack pointer register |
| user_sp_we | output | 1 | Write strobe, user stack pointer register |
| dslot_clr | output | 1 | Clear the delay-slot state |
| fatal_err | output | 1 | Nested bus fault seen (sticky) |

## Verification
The bench builds the block with its defaults: an 8-bit vector, a 2-bit delay-slot count, user flag at bit 8 and mask flag at bit 9. With these values vector 255 sits next to a base near the top of the address space, which brings the wrapping table address within reach. Delay-slot counts of 1 to 3 exercise the return rewind, and both placements of the user flag are tried. Random stalls on both read channels stretch the sequence, so that late requests and the nested bus-fault case meet a busy sequencer.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN = 32;

  // Index order is also the priority order (0 = highest)
  typedef enum logic [1:0] {
    EK_NMI  = 2'd0,
    EK_BFLT = 2'd1,
    EK_BRK  = 2'd2,
    EK_IRQ  = 2'd3
  } exc_kind_e;

  localparam int NUM_KINDS = 4;

  // Mode-stacking shift: top two bits stay, low 20 bits rise by ten
  function automatic logic [XLEN-1:0] stack_mode_bits(input logic [XLEN-1:0] f);
    return {f[31:30], f[19:0], 10'b0};
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             req_nmi,
  input  logic             req_bflt,
  input  logic             req_brk,
  input  logic             req_irq,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic [VEC_W-1:0] irq_vec,
  output logic             any_req,
  output exc_kind_e        kind,
  output logic [VEC_W-1:0] vec
);
  logic [NUM_KINDS-1:0] req_v;
  logic [NUM_KINDS-1:0] grant;

  assign req_v   = {req_irq, req_brk, req_bflt, req_nmi};
  assign any_req = |req_v;
  assign grant   = req_v & ~(req_v - NUM_KINDS'(1));

  always_comb begin
    kind = EK_IRQ;
    for (int i = NUM_KINDS - 1; i >= 0; i--) begin
      if (grant[i]) kind = exc_kind_e'(i);
    end
  end

  always_comb begin
    unique case (kind)
      EK_NMI:  vec = '0;
      EK_BFLT: vec = fault_vec;
      EK_BRK:  vec = trap_vec;
      default: vec = irq_vec;
    endcase
  end

  // R1
  always_comb begin
    single_grant_chk: assert ($onehot0(grant));
  end
endmodule

// File: rtl/exc_ctx_build.sv
module exc_ctx_build
  import exc_entry_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int DS_W  = 2,
  parameter int U_BIT = 8,
  parameter int M_BIT = 9
) (
  input  exc_kind_e        kind,
  input  logic [VEC_W-1:0] vec,
  input  logic [XLEN-1:0]  pc,
  input  logic [DS_W-1:0]  dslot,
  input  logic [XLEN-1:0]  flags,
  input  logic [XLEN-1:0]  sp,
  input  logic [XLEN-1:0]  ksp,
  output logic [XLEN-1:0]  ret_addr,
  output logic [XLEN-1:0]  status,
  output logic [XLEN-1:0]  flags_new,
  output logic             swap,
  output logic [XLEN-1:0]  sp_new,
  output logic [XLEN-1:0]  usp_new
);
  localparam int IDX_W = (VEC_W < 8) ? VEC_W : 8;

  logic [XLEN-1:0] masked;

  assign ret_addr = pc - XLEN'(dslot);

  always_comb begin
    status = '0;
    status[8 +: IDX_W] = vec[IDX_W-1:0];
  end

  always_comb begin
    masked = flags;
    if (kind == EK_NMI) masked[M_BIT] = 1'b0;
  end

  assign flags_new = stack_mode_bits(masked);
  assign swap      = flags[U_BIT];
  assign sp_new    = swap ? ksp : sp;
  assign usp_new   = sp;
endmodule

// File: rtl/exc_vec_fetch.sv
module exc_vec_fetch
  import exc_entry_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [XLEN-1:0]  vbase,
  input  logic [VEC_W-1:0] vec,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [XLEN-1:0]  rd_addr,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [XLEN-1:0]  rsp_data,
  output logic             busy,
  output logic             fin,
  output logic [XLEN-1:0]  pc_out
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} fst_e;
  fst_e st;

  localparam int PAD_W = XLEN - VEC_W - 2;

  assign rd_req_valid = (st == ST_REQ);
  assign rsp_ready    = (st == ST_WAIT);
  assign busy         = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      fin     <= 1'b0;
      rd_addr <= '0;
      pc_out  <= '0;
    end else begin
      fin <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          rd_addr <= vbase + {{PAD_W{1'b0}}, vec, 2'b00};
          st      <= ST_REQ;
        end
        ST_REQ: if (rd_req_ready) st <= ST_WAIT;
        ST_WAIT: if (rsp_valid) begin
          pc_out <= rsp_data;
          fin    <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

  // R11
  fin_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> $past(rsp_valid && rsp_ready));

  // R11
  fin_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int DS_W  = 2,
  parameter int U_BIT = 8,
  parameter int M_BIT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_nmi,
  input  logic             req_bflt,
  input  logic             req_brk,
  input  logic             req_irq,
  input  logic [VEC_W-1:0] trap_vec,
  input  logic [VEC_W-1:0] fault_vec,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [31:0]      cur_pc,
  input  logic [DS_W-1:0]  dslot_cnt,
  input  logic [31:0]      flags_in,
  input  logic [31:0]      vbase,
  input  logic [31:0]      sp_in,
  input  logic [31:0]      kern_sp_in,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [31:0]      rd_addr,
  input  logic             rd_rsp_valid,
  output logic             rd_rsp_ready,
  input  logic [31:0]      rd_rsp_data,
  output logic             busy,
  output logic             done,
  output logic [31:0]      new_pc,
  output logic [31:0]      ret_addr,
  output logic             ret_to_exc,
  output logic             ret_to_nmi,
  output logic [31:0]      status_out,
  output logic [31:0]      flags_out,
  output logic [31:0]      sp_out,
  output logic [31:0]      user_sp_out,
  output logic             user_sp_we,
  output logic             dslot_clr,
  output logic             fatal_err
);
  logic             any_req;
  exc_kind_e        sel_kind;
  logic [VEC_W-1:0] sel_vec;
  logic [XLEN-1:0]  c_ret, c_status, c_flags, c_sp, c_usp;
  logic             c_swap;
  logic             accept;

  exc_kind_e cap_kind;
  logic      cap_swap;
  logic      cap_ds_nz;

  exc_arbiter #(.VEC_W(VEC_W)) u_arb (
    .req_nmi  (req_nmi),
    .req_bflt (req_bflt),
    .req_brk  (req_brk),
    .req_irq  (req_irq),
    .trap_vec (trap_vec),
    .fault_vec(fault_vec),
    .irq_vec  (irq_vec),
    .any_req  (any_req),
    .kind     (sel_kind),
    .vec      (sel_vec)
  );

  exc_ctx_build #(.VEC_W(VEC_W), .DS_W(DS_W), .U_BIT(U_BIT), .M_BIT(M_BIT)) u_ctx (
    .kind     (sel_kind),
    .vec      (sel_vec),
    .pc       (cur_pc),
    .dslot    (dslot_cnt),
    .flags    (flags_in),
    .sp       (sp_in),
    .ksp      (kern_sp_in),
    .ret_addr (c_ret),
    .status   (c_status),
    .flags_new(c_flags),
    .swap     (c_swap),
    .sp_new   (c_sp),
    .usp_new  (c_usp)
  );

  assign accept = !busy && any_req && !fatal_err;

  exc_vec_fetch #(.VEC_W(VEC_W)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .vbase       (vbase),
    .vec         (sel_vec),
    .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready),
    .rd_addr     (rd_addr),
    .rsp_valid   (rd_rsp_valid),
    .rsp_ready   (rd_rsp_ready),
    .rsp_data    (rd_rsp_data),
    .busy        (busy),
    .fin         (done),
    .pc_out      (new_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_kind    <= EK_IRQ;
      cap_swap    <= 1'b0;
      cap_ds_nz   <= 1'b0;
      ret_addr    <= '0;
      status_out  <= '0;
      flags_out   <= '0;
      sp_out      <= '0;
      user_sp_out <= '0;
    end else if (accept) begin
      cap_kind    <= sel_kind;
      cap_swap    <= c_swap;
      cap_ds_nz   <= (dslot_cnt != '0);
      ret_addr    <= c_ret;
      status_out  <= c_status;
      flags_out   <= c_flags;
      sp_out      <= c_sp;
      user_sp_out <= c_usp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fatal_err <= 1'b0;
    else if (busy && cap_kind == EK_BFLT && req_bflt) fatal_err <= 1'b1;
  end

  assign ret_to_exc = done && (cap_kind != EK_NMI);
  assign ret_to_nmi = done && (cap_kind == EK_NMI);
  assign user_sp_we = done && cap_swap;
  assign dslot_clr  = done && cap_ds_nz;

  // R11
  strobe_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_to_exc || ret_to_nmi || user_sp_we || dslot_clr) |-> done);

  // R3
  nmi_mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_to_nmi |-> !flags_out[M_BIT + 10]);

  // R6
  status_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status_out[31:16] == '0 && status_out[7:0] == '0));

  // R10
  user_flag_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flags_out[U_BIT]);

  // R12
  kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cap_kind));

  // R13
  fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |=> fatal_err);

  // R13
  no_start_on_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal_err && !busy) |=> !busy);
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_nmi = 0, req_bflt = 0, req_brk = 0, req_irq = 0;
  logic [7:0] trap_vec = 0, fault_vec = 0, irq_vec = 0;
  logic [31:0] cur_pc = 0, flags_in = 0, vbase = 0, sp_in = 0, kern_sp_in = 0;
  logic [1:0] dslot_cnt = 0;
  logic rd_req_valid, rd_req_ready = 0, rd_rsp_ready, rd_rsp_valid = 0;
  logic [31:0] rd_addr, rd_rsp_data = 0;
  logic busy, done, ret_to_exc, ret_to_nmi, user_sp_we, dslot_clr, fatal_err;
  logic [31:0] new_pc, ret_addr, status_out, flags_out, sp_out, user_sp_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_seq #(.VEC_W(8), .DS_W(2), .U_BIT(8), .M_BIT(9)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_nmi(req_nmi), .req_bflt(req_bflt), .req_brk(req_brk), .req_irq(req_irq),
    .trap_vec(trap_vec), .fault_vec(fault_vec), .irq_vec(irq_vec),
    .cur_pc(cur_pc), .dslot_cnt(dslot_cnt), .flags_in(flags_in), .vbase(vbase),
    .sp_in(sp_in), .kern_sp_in(kern_sp_in),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .busy(busy), .done(done), .new_pc(new_pc), .ret_addr(ret_addr),
    .ret_to_exc(ret_to_exc), .ret_to_nmi(ret_to_nmi), .status_out(status_out),
    .flags_out(flags_out), .sp_out(sp_out), .user_sp_out(user_sp_out),
    .user_sp_we(user_sp_we), .dslot_clr(dslot_clr), .fatal_err(fatal_err)
  );

  function automatic logic [31:0] table_word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9bdf;
  endfunction

  // Memory responder with random stalls on both channels
  logic        pend = 0;
  logic [31:0] paddr = 0, last_addr = 0;
  int          wait_n = 0;
  always @(posedge clk) begin
    if (rd_req_valid && rd_req_ready) begin
      pend <= 1'b1; paddr <= rd_addr; last_addr <= rd_addr; wait_n <= $urandom % 3;
    end else if (rd_rsp_valid && rd_rsp_ready) pend <= 1'b0;
    else if (pend && wait_n != 0) wait_n <= wait_n - 1;
  end
  always @(negedge clk) begin
    rd_req_ready = ($urandom % 3) != 0;
    rd_rsp_valid = pend && (wait_n == 0);
    rd_rsp_data  = table_word(paddr);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Raise the request mask {irq,brk,bflt,nmi}, wait for done and compare
  task automatic run_entry(input logic [3:0] m, input bit late_irq);
    int idx = 0;
    logic [7:0] v;
    logic [31:0] fl, exp_fl;
    int cyc = 0;
    for (int i = 3; i >= 0; i--) if (m[i]) idx = i;
    case (idx)
      0: v = 8'd0;
      1: v = fault_vec;
      2: v = trap_vec;
      default: v = irq_vec;
    endcase
    fl = flags_in;
    if (idx == 0) fl[9] = 1'b0;
    exp_fl = {fl[31:30], fl[19:0], 10'b0};
    @(negedge clk);
    {req_irq, req_brk, req_bflt, req_nmi} = m;
    @(negedge clk);
    {req_irq, req_brk, req_bflt, req_nmi} = 4'b0;
    if (late_irq) begin
      req_irq = 1'b1; req_nmi = 1'b1;
      @(negedge clk);
      req_irq = 1'b0; req_nmi = 1'b0;
    end
    while (!done && cyc < 100) begin
      @(negedge clk); cyc++;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R11: actual no done expected done");
      return;
    end
    check("R1 kind strobe nmi", {31'b0, ret_to_nmi}, {31'b0, idx == 0});
    check("R2/R4/R5 strobe exc", {31'b0, ret_to_exc}, {31'b0, idx != 0});
    check("R6 status", status_out, {16'b0, v, 8'b0});
    check("R7 ret", ret_addr, cur_pc - {30'b0, dslot_cnt});
    check("R7 dslot_clr", {31'b0, dslot_clr}, {31'b0, dslot_cnt != 0});
    check("R8 addr", last_addr, vbase + {22'b0, v, 2'b00});
    check("R11 new_pc", new_pc, table_word(vbase + {22'b0, v, 2'b00}));
    check("R10 flags", flags_out, exp_fl);
    check("R9 sp", sp_out, flags_in[8] ? kern_sp_in : sp_in);
    check("R9 usp we", {31'b0, user_sp_we}, {31'b0, flags_in[8]});
    if (flags_in[8]) check("R9 usp", user_sp_out, sp_in);
    @(negedge clk);
    check("R11 done single", {31'b0, done}, 32'd0);
    check("R11 strobes low", {28'b0, ret_to_exc, ret_to_nmi, user_sp_we, dslot_clr}, 32'd0);
  endtask

  task automatic rand_ctx();
    trap_vec = 8'($urandom); fault_vec = 8'($urandom); irq_vec = 8'($urandom);
    cur_pc = $urandom; dslot_cnt = 2'($urandom); flags_in = $urandom;
    vbase = $urandom; sp_in = $urandom; kern_sp_in = $urandom;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R14
    check("R14 reset", {26'b0, busy, done, rd_req_valid, ret_to_exc, ret_to_nmi, fatal_err}, 32'd0);
    check("R14 strobes", {30'b0, user_sp_we, dslot_clr}, 32'd0);

    // R1 priority cases
    rand_ctx(); run_entry(4'b1111, 0);
    rand_ctx(); run_entry(4'b1110, 0);
    rand_ctx(); run_entry(4'b1100, 0);
    rand_ctx(); run_entry(4'b1000, 0);
    // R3 NMI with mask and user flags set
    rand_ctx(); flags_in = flags_in | 32'h0000_0300; run_entry(4'b0001, 0);
    // R9 user flag clear, R7 no delay slot
    rand_ctx(); flags_in[8] = 1'b0; dslot_cnt = 2'd0; run_entry(4'b0100, 0);
    // R8 table address wrap, R7 rewind across zero
    rand_ctx(); vbase = 32'hFFFF_FFF0; irq_vec = 8'hFF; cur_pc = 32'd1; dslot_cnt = 2'd3;
    run_entry(4'b1000, 0);

    // R12 late requests ignored
    rand_ctx(); run_entry(4'b0100, 1);
    repeat (6) @(negedge clk);
    check("R12 no later entry", {31'b0, busy}, 32'd0);

    for (int k = 0; k < 40; k++) begin
      logic [3:0] m;
      rand_ctx();
      m = 4'($urandom);
      if (m == 0) m = 4'b1000;
      run_entry(m, 0);
    end

    // R13 nested bus fault
    rand_ctx();
    @(negedge clk); req_bflt = 1'b1;
    repeat (3) @(negedge clk);
    req_bflt = 1'b0;
    repeat (20) @(negedge clk);
    check("R13 fatal set", {31'b0, fatal_err}, 32'd1);
    req_irq = 1'b1;
    repeat (5) @(negedge clk);
    check("R13 no accept", {31'b0, busy}, 32'd0);
    req_irq = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R14 fatal cleared", {31'b0, fatal_err}, 32'd0);

    finish_run();
  end
endmodule